// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines and presents them to a processor as one interrupt output. Each line has its own enable bit. Software sets enable bits through one register and clears them through another, and reads the resulting mask back from a third. Software can also raise any line itself. A request is pending when its line is high or its software bit is set, and its enable bit is on. The lowest-numbered pending line wins. The controller then copies that line's entry from an internal 32-word vector table into a readable vector register and drives the interrupt output. The output polarity is programmable.

Software handles the interrupt and then writes anything to the end-of-interrupt register. That write closes the current interrupt and clears the software request of the serviced line. The controller then takes the next pending line, if there is one. External lines pass through a two-flop synchronizer before they are used. The synchronized levels can be read back raw, without the mask applied.

The bus is a 32-bit Wishbone-style slave with byte addresses. Each access gets a single-cycle acknowledge one clock after the request.

Register layout (byte offsets):

| Offset | Access | Contents |
|---|---|---|
| 0x00 | read/write | bit 0 enable, bit 1 polarity |
| 0x04 | read | synchronized line levels |
| 0x08 | write | set enable bits |
| 0x0C | write | clear enable bits |
| 0x10 | read | enable mask |
| 0x14 | read | latched vector |
| 0x18 | write | software requests |
| 0x1C | write | end of interrupt |
| 0x80 to 0xFF | read/write | vector table |

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0, the mask reads 0, the vector register reads 0, and `irq_o` is 1, which is the inactive level for the active-low polarity selected by reset.
- R2: Every bus request is acknowledged for exactly one cycle, on the clock after the request (`cyc_i` and `stb_i` high while `ack_o` is low). Read data is valid while `ack_o` is high.
- R3: Writing offset 0x08 turns on the enable bit of every line whose data bit is 1. Data bits that are 0 leave their enable bits unchanged. The mask is read at offset 0x10, bit n for line n.
- R4: Writing offset 0x0C turns off the enable bit of every line whose data bit is 1. Data bits that are 0 leave their enable bits unchanged.
- R5: Offset 0x04 returns the level of each line, bit n for line n, two clocks after the line changes. At offsets 0x04 and 0x10, bits at or above `N_LINES` read 0.
- R6: Word n of the vector table sits at offset 0x80 + 4n and can be read and written. When line n is taken, word n is copied into the vector register at offset 0x14.
- R7: When no interrupt is outstanding and the block is enabled, the lowest-numbered line that is pending and enabled is taken.
- R8: An outstanding interrupt is not replaced when a lower-numbered line becomes pending. The vector register and `irq_o` hold their values until the acknowledge.
- R9: A write of any data to offset 0x1C ends the outstanding interrupt and clears the software request of the serviced line. If another line is pending, it is taken on a later clock.
- R10: Writing offset 0x18 sets the software request of every line whose data bit is 1, and a software request acts like a high line. Data bits that are 0 change nothing.
- R11: Control bit 0 enables the block; while it is 0 no line is taken and `irq_o` stays inactive. Control bit 1 selects the polarity: 1 makes `irq_o` active high, and 0 makes it active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| adr_i | input | 8 | Byte address |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data |
| ack_o | output | 1 | Acknowledge |
| irq_lines_i | input | N_LINES | Interrupt request lines |
| irq_o | output | 1 | Interrupt output, polarity set by control bit 1 |

## Verification
The hardest case to reach is a lower-numbered line arriving while another interrupt is still waiting for its acknowledge. The bench first lets a higher-numbered line be taken. It then raises a lower-numbered line and checks that the vector register does not move. It also lowers the first line before the acknowledge, so that the acknowledge must switch over to the newcomer. A second case is a software request that is pending while its line is masked or the block is disabled. Unmasking or enabling must then take that line on its own, which the bench checks through the vector register and `irq_o` under both polarities.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cyc_i,
  input  logic               stb_i,
  input  logic               we_i,
  input  logic [7:0]         adr_i,
  input  logic [31:0]        dat_i,
  output logic [31:0]        dat_o,
  output logic               ack_o,
  input  logic [N_LINES-1:0] irq_lines_i,
  output logic               irq_o
);
  localparam int NW = N_LINES;
  localparam int TBL = 32;

  logic [NW-1:0] sync1_q, sync2_q, mask_q, swi_q, pend;
  logic          en_q, pol_q, insvc_q, ack_q, any;
  logic [4:0]    cur_q, sel;
  logic [31:0]   var_q, rdata_q, rdata, pend32;
  logic [31:0]   vt [TBL];

  wire         req    = cyc_i & stb_i & ~ack_q;
  wire         wr     = req & we_i;
  wire [5:0]   wa     = adr_i[7:2];
  wire [NW-1:0] wdat  = dat_i[NW-1:0];
  wire         ctl_wr = wr && wa == 6'h00;
  wire         ier_wr = wr && wa == 6'h02;
  wire         idr_wr = wr && wa == 6'h03;
  wire         swi_wr = wr && wa == 6'h06;
  wire         eoi_wr = wr && wa == 6'h07;
  wire         vt_wr  = wr && wa[5];

  logic unused_ok;
  assign unused_ok = ^{adr_i[1:0]};

  assign pend   = (sync2_q | swi_q) & mask_q;
  assign pend32 = 32'(pend);
  assign any    = |pend;

  always_comb begin
    sel = '0;
    for (int i = NW - 1; i >= 0; i--)
      if (pend[i]) sel = 5'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= irq_lines_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (ctl_wr) begin
        en_q  <= dat_i[0];
        pol_q <= dat_i[1];
      end
      if (ier_wr) mask_q <= mask_q | wdat;
      if (idr_wr) mask_q <= mask_q & ~wdat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swi_q <= '0;
    end else if (swi_wr) begin
      swi_q <= swi_q | wdat;
    end else if (eoi_wr && insvc_q) begin
      swi_q[cur_q] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insvc_q <= 1'b0;
      cur_q   <= '0;
      var_q   <= '0;
    end else if (insvc_q) begin
      if (eoi_wr) insvc_q <= 1'b0;
    end else if (en_q && any) begin
      insvc_q <= 1'b1;
      cur_q   <= sel;
      var_q   <= vt[sel];
    end
  end

  always_ff @(posedge clk_i) begin
    if (vt_wr) vt[wa[4:0]] <= dat_i;
  end

  always_comb begin
    rdata = '0;
    if (wa[5]) begin
      rdata = vt[wa[4:0]];
    end else begin
      case (wa)
        6'h00:   rdata = {30'd0, pol_q, en_q};
        6'h01:   rdata = 32'(sync2_q);
        6'h04:   rdata = 32'(mask_q);
        6'h05:   rdata = var_q;
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req;
      rdata_q <= req ? rdata : '0;
    end
  end

  assign ack_o = ack_q;
  assign dat_o = rdata_q;
  assign irq_o = pol_q ? (en_q & insvc_q) : ~(en_q & insvc_q);

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> ack_q); // R2
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q); // R2
  AST_SET_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_wr |=> (mask_q & $past(wdat)) == $past(wdat)); // R3
  AST_CLR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idr_wr |=> (mask_q & $past(wdat)) == '0); // R4
  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(insvc_q) |-> ((($past(pend32) >> cur_q) & 32'd1) == 32'd1)
      && (($past(pend32) & ((32'd1 << cur_q) - 32'd1)) == 32'd0)); // R7
  AST_NO_PREEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insvc_q && !eoi_wr |=> insvc_q && $stable(cur_q) && $stable(var_q)); // R8
  AST_EOI_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr && insvc_q |=> !insvc_q); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> irq_o == ~pol_q); // R11
endmodule

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc = 0, stb = 0, we = 0;
  logic [7:0] adr = '0;
  logic [31:0] wdat = '0, rdat;
  logic ack, irq;
  logic [N-1:0] lines = '0;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  vec_irq_ctrl #(.N_LINES(N)) u_vec_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(wdat), .dat_o(rdat), .ack_o(ack),
    .irq_lines_i(lines), .irq_o(irq));

  function automatic logic [31:0] vec(input int i);
    return 32'h1000_0000 + 32'(i) * 32'h0000_0111;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
    @(negedge clk);
    check("R2 write ack", 32'(ack), 32'd1);
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    check("R2 ack single cycle", 32'(ack), 32'd0);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = a;
    @(negedge clk);
    check("R2 read ack", 32'(ack), 32'd1);
    d = rdat;
    cyc = 0; stb = 0;
  endtask

  task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    check("R1 irq inactive", 32'(irq), 32'd1);
    expect_reg("R1 control", 8'h00, 32'd0);
    expect_reg("R1 mask", 8'h10, 32'd0);
    expect_reg("R1 vector", 8'h14, 32'd0);
  endtask

  task automatic t_mask;
    bus_write(8'h08, 32'h0000_00A5);
    expect_reg("R3 set bits", 8'h10, 32'h0000_00A5);
    bus_write(8'h08, 32'h0);
    expect_reg("R3 zero no effect", 8'h10, 32'h0000_00A5);
    bus_write(8'h0C, 32'h0000_0005);
    expect_reg("R4 clear bits", 8'h10, 32'h0000_00A0);
    bus_write(8'h0C, 32'h0);
    expect_reg("R4 zero no effect", 8'h10, 32'h0000_00A0);
    bus_write(8'h08, 32'hFFFF_FFFF);
    expect_reg("R5 mask unused zero", 8'h10, 32'h0000_00FF);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    expect_reg("R4 clear all", 8'h10, 32'h0);
  endtask

  task automatic t_table;
    for (int i = 0; i < 32; i++) bus_write(8'h80 + 8'(i * 4), vec(i));
    expect_reg("R6 table word 0", 8'h80, vec(0));
    expect_reg("R6 table word 17", 8'hC4, vec(17));
    expect_reg("R6 table word 31", 8'hFC, vec(31));
  endtask

  task automatic t_raw;
    lines = 8'h5A;
    repeat (3) @(negedge clk);
    expect_reg("R5 raw levels", 8'h04, 32'h0000_005A);
    lines = 8'h00;
    repeat (3) @(negedge clk);
    expect_reg("R5 raw cleared", 8'h04, 32'h0);
    check("R11 disabled with lines idle", 32'(irq), 32'd1);
  endtask

  task automatic t_priority;
    bus_write(8'h00, 32'd1);
    bus_write(8'h08, 32'h0000_00FF);
    lines = 8'h28;
    repeat (4) @(negedge clk);
    check("R11 active low", 32'(irq), 32'd0);
    expect_reg("R7 lowest taken", 8'h14, vec(3));
    lines = 8'h2A;
    repeat (4) @(negedge clk);
    expect_reg("R8 no preemption", 8'h14, vec(3));
    check("R8 irq held", 32'(irq), 32'd0);
    lines = 8'h22;
    repeat (3) @(negedge clk);
    bus_write(8'h1C, 32'h0);
    repeat (2) @(negedge clk);
    expect_reg("R9 next pending taken", 8'h14, vec(1));
    lines = 8'h00;
    repeat (3) @(negedge clk);
    bus_write(8'h1C, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    check("R9 idle after ack", 32'(irq), 32'd1);
  endtask

  task automatic t_swi;
    bus_write(8'h18, 32'h0000_0010);
    repeat (2) @(negedge clk);
    check("R10 soft request raises irq", 32'(irq), 32'd0);
    expect_reg("R10 soft vector", 8'h14, vec(4));
    bus_write(8'h18, 32'h0);
    bus_write(8'h1C, 32'h0);
    repeat (3) @(negedge clk);
    check("R9 soft request cleared", 32'(irq), 32'd1);
  endtask

  task automatic t_masked_soft;
    bus_write(8'h0C, 32'h0000_0040);
    bus_write(8'h18, 32'h0000_0040);
    repeat (3) @(negedge clk);
    check("R4 masked line silent", 32'(irq), 32'd1);
    bus_write(8'h08, 32'h0000_0040);
    repeat (2) @(negedge clk);
    check("R3 unmask takes line", 32'(irq), 32'd0);
    expect_reg("R6 vector of line 6", 8'h14, vec(6));
    bus_write(8'h1C, 32'h0);
    repeat (2) @(negedge clk);
    check("R9 ack line 6", 32'(irq), 32'd1);
  endtask

  task automatic t_enable_pol;
    bus_write(8'h00, 32'd0);
    bus_write(8'h18, 32'h0000_0004);
    repeat (3) @(negedge clk);
    check("R11 disabled no irq", 32'(irq), 32'd1);
    bus_write(8'h00, 32'd3);
    repeat (2) @(negedge clk);
    check("R11 active high", 32'(irq), 32'd1);
    expect_reg("R11 taken when enabled", 8'h14, vec(2));
    expect_reg("R11 control readback", 8'h00, 32'd3);
    bus_write(8'h00, 32'd2);
    @(negedge clk);
    check("R11 disabled high polarity inactive", 32'(irq), 32'd0);
    bus_write(8'h00, 32'd3);
    bus_write(8'h1C, 32'h0);
    repeat (2) @(negedge clk);
    check("R9 ack high polarity", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_table();
    t_raw();
    t_priority();
    t_swi();
    t_masked_soft();
    t_enable_pol();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule